// File: doc/BRIEF.md
# Wishbone Register-Array Bridge

This block is a Wishbone classic slave. It maps a small register array into a 32-bit byte address space. A bus write stores a full 32-bit word through the array's single write port. A bus read fetches a word through one of the array's two read ports, and the port is chosen by one offset bit in the address. The master holds `cyc`/`stb` for a single cycle and then waits for `ack`. The bridge therefore latches the request when it accepts it. It then runs the array access and returns a one-cycle acknowledge once the result is final.

The array itself sits outside this block. The array registers its inputs on one edge. A write takes effect on the following edge, and read data is registered on the following edge as well, so read data is available two edges after the request is issued. The control and configuration windows are decoded only as stubs. Like any other address that is not mapped, they are acknowledged and return zero, so the bus never stalls.

Top module: `wb_array_bridge`

## Requirements
- R1: While `rst_ni` is low, `wb_ack_o` is 0, `wb_dat_o` is 0 and all three array enables are 0.
- R2: A write with `wb_sel_i` = 4'hF to `0x0010_0000 + i` (address bits 15..5 all zero) drives the write port for exactly one cycle with index i and the full `wb_dat_i` word. `wb_ack_o` rises 2 cycles after the edge that accepted the request, with `wb_dat_o` = 0.
- R3: A read from `0x0010_0000 + i` uses read port 0. A read from `0x0010_4000 + i` (address bit 14 set) uses read port 1. Each read pulses exactly one read enable, with index i.
- R4: For a read, `wb_ack_o` rises 3 cycles after the accepting edge, and `wb_dat_o` holds the array word of entry i in the cycle that `ack` is high.
- R5: `wb_ack_o` is high for exactly one cycle per accepted request.
- R6: A read accepted on the edge that ends a write's ack cycle, to the same entry, returns the newly written word.
- R7: An access outside the array window, an array-window address with any of bits 15, 13..5 set, any access to the control window (`0x0001_xxxx`) or the configuration window (`0x0000_xxxx`), or a write to the port-1 window is acknowledged 1 cycle after acceptance with `wb_dat_o` = 0. It touches no array port.
- R8: A write whose `wb_sel_i` is not 4'hF is acknowledged like an unmapped access and leaves the array unchanged.
- R9: A `cyc`/`stb` pulse that arrives while a request is still outstanding is ignored. It produces no ack and no array access.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | 1 = write |
| wb_adr_i | input | 32 | Byte address |
| wb_sel_i | input | 4 | Byte selects |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ack |
| wb_ack_o | output | 1 | One-cycle acknowledge |
| arr_wr_en_o | output | 1 | Array write enable |
| arr_wr_idx_o | output | 5 | Array write index |
| arr_wr_dat_o | output | 32 | Array write data |
| arr_rd0_en_o | output | 1 | Read port 0 enable |
| arr_rd0_idx_o | output | 5 | Read port 0 index |
| arr_rd0_dat_i | input | 32 | Read port 0 data |
| arr_rd1_en_o | output | 1 | Read port 1 enable |
| arr_rd1_idx_o | output | 5 | Read port 1 index |
| arr_rd1_dat_i | input | 32 | Read port 1 data |

## Verification
The acknowledge is due a fixed number of cycles after the accepting edge:
- 1 cycle for an unmapped or dropped access.
- 2 cycles for a committed write.
- 3 cycles for a read.

The driver counts edges, notes the edge that accepted each request, and queues the expected word together with the exact cycle the ack is due. The monitor samples on falling edges and compares both the data and the cycle of every ack. An ack that arrives when nothing is queued, or that lasts two cycles, is a failure. Effects that should be absent are checked at the array ports and by reading the entry back later: ignored strobes, partial-select writes and writes to the port-1 window.

// File: rtl/wb_array_bridge_pkg.sv
package wb_array_bridge_pkg;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_WR   = 3'd1,
    ACC_RD0  = 3'd2,
    ACC_RD1  = 3'd3,
    ACC_CTRL = 3'd4,
    ACC_CFG  = 3'd5
  } acc_kind_e;

endpackage

// File: rtl/wb_addr_decode.sv
module wb_addr_decode
  import wb_array_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned SEL_W        = 4,
  parameter int unsigned IDX_W        = 5,
  parameter int unsigned WIN_W        = 16,
  parameter int unsigned PORT_SEL_BIT = 14,
  parameter logic [ADDR_W-1:0] ARRAY_BASE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] CTRL_BASE  = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] CFG_BASE   = 32'h0000_0000
) (
  input  logic [ADDR_W-1:0] adr_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [ADDR_W-1:0] ONE       = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] LOW_MASK  = {{(ADDR_W-WIN_W){1'b0}}, {WIN_W{1'b1}}};
  localparam logic [ADDR_W-1:0] IDX_MASK  = {{(ADDR_W-IDX_W){1'b0}}, {IDX_W{1'b1}}};
  localparam logic [ADDR_W-1:0] PORT_MASK = ONE << PORT_SEL_BIT;
  localparam logic [ADDR_W-1:0] PAD_MASK  = LOW_MASK & ~IDX_MASK & ~PORT_MASK;

  logic arr_hit, ctrl_hit, cfg_hit, pad_ok, port_bit;

  assign arr_hit  = (adr_i & ~LOW_MASK) == (ARRAY_BASE & ~LOW_MASK);
  assign ctrl_hit = (adr_i & ~LOW_MASK) == (CTRL_BASE & ~LOW_MASK);
  assign cfg_hit  = (adr_i & ~LOW_MASK) == (CFG_BASE & ~LOW_MASK);
  assign pad_ok   = (adr_i & PAD_MASK) == '0;
  assign port_bit = |(adr_i & PORT_MASK);

  always_comb begin
    kind_o = ACC_NONE;
    if (arr_hit && pad_ok) begin
      if (we_i) begin
        // only full-word writes through the port-0 window reach the array
        if (!port_bit && (&sel_i)) kind_o = ACC_WR;
      end else begin
        kind_o = port_bit ? ACC_RD1 : ACC_RD0;
      end
    end else if (ctrl_hit) begin
      kind_o = ACC_CTRL;
    end else if (cfg_hit) begin
      kind_o = ACC_CFG;
    end
  end

  assign idx_o = adr_i[IDX_W-1:0];

endmodule

// File: rtl/wb_req_capture.sv
module wb_req_capture
  import wb_array_bridge_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  acc_kind_e         kind_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] dat_i,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] dat_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= ACC_NONE;
      idx_o  <= '0;
      dat_o  <= '0;
    end else if (take_i) begin
      kind_o <= kind_i;
      idx_o  <= idx_i;
      dat_o  <= dat_i;
    end
  end

endmodule

// File: rtl/wb_access_seq.sv
module wb_access_seq
  import wb_array_bridge_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RD_ACK_DLY = 3,
  parameter int unsigned WR_ACK_DLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  acc_kind_e         kind_live_i,
  input  acc_kind_e         kind_q_i,
  input  logic [DATA_W-1:0] rd0_dat_i,
  input  logic [DATA_W-1:0] rd1_dat_i,
  output logic              take_o,
  output logic              issue_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] dat_o
);

  localparam int unsigned MAX_DLY = (RD_ACK_DLY > WR_ACK_DLY) ? RD_ACK_DLY : WR_ACK_DLY;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;
  logic [DATA_W-1:0] rd_sel;

  assign take_o = req_i && !busy_q;

  always_comb begin
    unique case (kind_live_i)
      ACC_WR:           load = CNT_W'(WR_ACK_DLY);
      ACC_RD0, ACC_RD1: load = CNT_W'(RD_ACK_DLY);
      default:          load = CNT_W'(1);
    endcase
  end

  always_comb begin
    unique case (kind_q_i)
      ACC_RD0: rd_sel = rd0_dat_i;
      ACC_RD1: rd_sel = rd1_dat_i;
      default: rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      issue_o <= 1'b0;
      ack_o   <= 1'b0;
      dat_o   <= '0;
    end else begin
      ack_o   <= 1'b0;
      issue_o <= 1'b0;
      if (take_o) begin
        busy_q  <= 1'b1;
        cnt_q   <= load;
        issue_o <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          ack_o  <= 1'b1;
          dat_o  <= rd_sel;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/wb_array_bridge.sv
module wb_array_bridge
  import wb_array_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned SEL_W        = DATA_W / 8,
  parameter int unsigned IDX_W        = 5,
  parameter int unsigned WIN_W        = 16,
  parameter int unsigned PORT_SEL_BIT = 14,
  parameter int unsigned ARR_RD_LAT   = 2,
  parameter int unsigned ARR_WR_LAT   = 2,
  parameter logic [ADDR_W-1:0] ARRAY_BASE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] CTRL_BASE  = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] CFG_BASE   = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [SEL_W-1:0]  wb_sel_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic              arr_wr_en_o,
  output logic [IDX_W-1:0]  arr_wr_idx_o,
  output logic [DATA_W-1:0] arr_wr_dat_o,
  output logic              arr_rd0_en_o,
  output logic [IDX_W-1:0]  arr_rd0_idx_o,
  input  logic [DATA_W-1:0] arr_rd0_dat_i,
  output logic              arr_rd1_en_o,
  output logic [IDX_W-1:0]  arr_rd1_idx_o,
  input  logic [DATA_W-1:0] arr_rd1_dat_i
);

  // read ack one edge after array output register, write ack on commit edge
  localparam int unsigned RD_ACK_DLY = ARR_RD_LAT + 1;
  localparam int unsigned WR_ACK_DLY = ARR_WR_LAT;

  acc_kind_e         kind_live, kind_q;
  logic [IDX_W-1:0]  idx_live, idx_q;
  logic [DATA_W-1:0] dat_q;
  logic              take, issue;

  wb_addr_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .WIN_W(WIN_W),
    .PORT_SEL_BIT(PORT_SEL_BIT), .ARRAY_BASE(ARRAY_BASE),
    .CTRL_BASE(CTRL_BASE), .CFG_BASE(CFG_BASE)
  ) u_dec (
    .adr_i (wb_adr_i),
    .we_i  (wb_we_i),
    .sel_i (wb_sel_i),
    .kind_o(kind_live),
    .idx_o (idx_live)
  );

  wb_req_capture #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .kind_i(kind_live),
    .idx_i (idx_live),
    .dat_i (wb_dat_i),
    .kind_o(kind_q),
    .idx_o (idx_q),
    .dat_o (dat_q)
  );

  wb_access_seq #(
    .DATA_W(DATA_W), .RD_ACK_DLY(RD_ACK_DLY), .WR_ACK_DLY(WR_ACK_DLY)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (wb_cyc_i && wb_stb_i),
    .kind_live_i(kind_live),
    .kind_q_i   (kind_q),
    .rd0_dat_i  (arr_rd0_dat_i),
    .rd1_dat_i  (arr_rd1_dat_i),
    .take_o     (take),
    .issue_o    (issue),
    .ack_o      (wb_ack_o),
    .dat_o      (wb_dat_o)
  );

  assign arr_wr_en_o   = issue && (kind_q == ACC_WR);
  assign arr_rd0_en_o  = issue && (kind_q == ACC_RD0);
  assign arr_rd1_en_o  = issue && (kind_q == ACC_RD1);
  assign arr_wr_idx_o  = idx_q;
  assign arr_rd0_idx_o = idx_q;
  assign arr_rd1_idx_o = idx_q;
  assign arr_wr_dat_o  = dat_q;

endmodule

// File: rtl/wb_array_bridge_chk.sv
module wb_array_bridge_chk #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SEL_W      = 4,
  parameter int unsigned RD_ACK_DLY = 3,
  parameter int unsigned WR_ACK_DLY = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wb_cyc_i,
  input logic              wb_stb_i,
  input logic              wb_we_i,
  input logic              port_bit_i,
  input logic [SEL_W-1:0]  wb_sel_i,
  input logic [DATA_W-1:0] wb_dat_i,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic              wb_ack_o,
  input logic              arr_wr_en_o,
  input logic [DATA_W-1:0] arr_wr_dat_o,
  input logic              arr_rd0_en_o,
  input logic              arr_rd1_en_o
);

  localparam int unsigned GAP_MAX = RD_ACK_DLY + WR_ACK_DLY + 1;
  localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1);

  logic             any_en;
  logic [GAP_W-1:0] gap_q;
  logic             last_rd_q;

  assign any_en = arr_wr_en_o || arr_rd0_en_o || arr_rd1_en_o;

  // cycles since the last array issue, cleared by ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      last_rd_q <= 1'b0;
    end else if (any_en) begin
      gap_q     <= GAP_W'(1);
      last_rd_q <= arr_rd0_en_o || arr_rd1_en_o;
    end else if (wb_ack_o) begin
      gap_q <= '0;
    end else if (gap_q != '0 && gap_q != GAP_W'(GAP_MAX)) begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!wb_ack_o && wb_dat_o == '0 && !any_en); // R1
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o); // R5

  AST_WR_ACK_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_ack_o && !last_rd_q && gap_q != '0) |-> gap_q == GAP_W'(WR_ACK_DLY)); // R2

  AST_WR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_en_o |-> arr_wr_dat_o == $past(wb_dat_i)); // R2

  AST_RD_ACK_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_ack_o && last_rd_q && gap_q != '0) |-> gap_q == GAP_W'(RD_ACK_DLY)); // R4

  AST_RD1_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rd1_en_o |-> $past(port_bit_i) && !$past(wb_we_i)); // R3

  AST_RD0_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rd0_en_o |-> !$past(port_bit_i) && !$past(wb_we_i)); // R3

  AST_NONREAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_ack_o && !(last_rd_q && gap_q != '0)) |-> wb_dat_o == '0); // R7

  AST_WR_FULL_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_en_o |-> ($past(wb_sel_i) == '1) && $past(wb_we_i)
                    && !$past(port_bit_i)); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_en |-> (gap_q == '0) && $onehot0({arr_wr_en_o, arr_rd0_en_o, arr_rd1_en_o})); // R9

  AST_ISSUE_FROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_en |-> $past(wb_cyc_i && wb_stb_i)); // R9

endmodule

bind wb_array_bridge wb_array_bridge_chk #(
  .DATA_W(DATA_W), .SEL_W(SEL_W),
  .RD_ACK_DLY(ARR_RD_LAT + 1), .WR_ACK_DLY(ARR_WR_LAT)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wb_cyc_i    (wb_cyc_i),
  .wb_stb_i    (wb_stb_i),
  .wb_we_i     (wb_we_i),
  .port_bit_i  (wb_adr_i[PORT_SEL_BIT]),
  .wb_sel_i    (wb_sel_i),
  .wb_dat_i    (wb_dat_i),
  .wb_dat_o    (wb_dat_o),
  .wb_ack_o    (wb_ack_o),
  .arr_wr_en_o (arr_wr_en_o),
  .arr_wr_dat_o(arr_wr_dat_o),
  .arr_rd0_en_o(arr_rd0_en_o),
  .arr_rd1_en_o(arr_rd1_en_o)
);

// File: tb/wb_array_bridge_tb_top.sv
`timescale 1ns/1ps
module wb_array_bridge_tb_top;

  localparam int IDX_W = 5;
  localparam int NENT  = 1 << IDX_W;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] P1   = 32'h0000_4000;

  logic        clk, rst_n;
  logic        cyc, stb, we;
  logic [31:0] adr, wdat;
  logic [3:0]  sel;
  logic [31:0] rdat;
  logic        ack;
  logic        wr_en, rd0_en, rd1_en;
  logic [IDX_W-1:0] wr_idx, rd0_idx, rd1_idx;
  logic [31:0] wr_dat, rd0_dat, rd1_dat;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  wb_array_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .arr_wr_en_o(wr_en), .arr_wr_idx_o(wr_idx), .arr_wr_dat_o(wr_dat),
    .arr_rd0_en_o(rd0_en), .arr_rd0_idx_o(rd0_idx), .arr_rd0_dat_i(rd0_dat),
    .arr_rd1_en_o(rd1_en), .arr_rd1_idx_o(rd1_idx), .arr_rd1_dat_i(rd1_dat)
  );

  function automatic logic [31:0] init_word(input int i);
    return {8'hA5, 8'(i), 8'h5A, ~8'(i)};
  endfunction

  // array model: inputs registered, write/read on the following edge
  logic [31:0] mem [NENT];
  logic        wq_en, r0q_en, r1q_en;
  logic [IDX_W-1:0] wq_idx, r0q_idx, r1q_idx;
  logic [31:0] wq_dat;
  int wr_hits, rd0_hits, rd1_hits;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) mem[i] <= init_word(i);
      wq_en <= 0; r0q_en <= 0; r1q_en <= 0;
      wq_idx <= '0; r0q_idx <= '0; r1q_idx <= '0; wq_dat <= '0;
      rd0_dat <= '0; rd1_dat <= '0;
      wr_hits <= 0; rd0_hits <= 0; rd1_hits <= 0;
    end else begin
      wq_en <= wr_en; wq_idx <= wr_idx; wq_dat <= wr_dat;
      r0q_en <= rd0_en; r0q_idx <= rd0_idx;
      r1q_en <= rd1_en; r1q_idx <= rd1_idx;
      if (wq_en) mem[wq_idx] <= wq_dat;
      if (r0q_en) rd0_dat <= mem[r0q_idx];
      if (r1q_en) rd1_dat <= mem[r1q_idx];
      if (wr_en) wr_hits <= wr_hits + 1;
      if (rd0_en) rd0_hits <= rd0_hits + 1;
      if (rd1_en) rd1_hits <= rd1_hits + 1;
    end
  end

  // scoreboard
  typedef struct {
    logic [31:0] dat;
    longint      due;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  int pending;
  int n_chk, n_fail;
  longint cyc_cnt;
  logic [31:0] shadow [NENT];
  bit prev_ack, done, reported;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ack && prev_ack) chk(1'b0, "R5 ack wider than one cycle", 32'd1, 32'd0);
      if (ack) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9 ack with nothing outstanding", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(rdat == e.dat, {e.tag, " data"}, rdat, e.dat);
          chk(cyc_cnt == e.due, {e.tag, " ack cycle"}, 32'(cyc_cnt), 32'(e.due));
          pending--;
        end
      end
      prev_ack = ack;
    end
  end

  task automatic bus_op(input logic [31:0] a, input bit w, input logic [31:0] d,
                        input logic [3:0] s, input logic [31:0] exp_d, input int lat,
                        input string tag, input bit stray = 0,
                        input logic [31:0] s_adr = '0, input logic [31:0] s_dat = '0);
    exp_t e;
    cyc = 1; stb = 1; we = w; adr = a; wdat = d; sel = s;
    @(posedge clk);
    @(negedge clk);
    e.dat = exp_d; e.due = cyc_cnt + lat; e.tag = tag;
    sb_q.push_back(e);
    pending++;
    if (stray) begin
      we = 1; adr = s_adr; wdat = s_dat; sel = 4'hF;
      @(negedge clk);
    end
    cyc = 0; stb = 0; we = 0; adr = '0; wdat = '0; sel = '0;
    wait (pending == 0);
  endtask

  task automatic wr(input int i, input logic [31:0] d, input string tag);
    bus_op(BASE + 32'(i), 1, d, 4'hF, 32'd0, 2, tag);
    shadow[i] = d;
  endtask

  task automatic rd(input int i, input bit p1, input string tag);
    bus_op(BASE + (p1 ? P1 : 32'd0) + 32'(i), 0, '0, 4'hF, shadow[i], 3, tag);
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog expired act=hung exp=all acks");
      report();
    end
  end

  initial begin
    int w0, r0, r1;
    rst_n = 0; cyc = 0; stb = 0; we = 0; adr = '0; wdat = '0; sel = '0;
    cyc_cnt = 0; pending = 0;
    for (int i = 0; i < NENT; i++) shadow[i] = init_word(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ack == 0, "R1 ack in reset", 32'(ack), 0);
    chk(rdat == 0, "R1 data in reset", rdat, 0);
    chk({wr_en, rd0_en, rd1_en} == 0, "R1 enables in reset", 32'({wr_en, rd0_en, rd1_en}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    wr(3, 32'h1234_5678, "R2 write idx3");
    chk(wr_hits == 1, "R2 write port used once", 32'(wr_hits), 1);
    rd(3, 0, "R6 read after write idx3");
    chk(rd0_hits == 1 && rd1_hits == 0, "R3 port0 read", 32'(rd0_hits), 1);
    rd(3, 1, "R3 port1 idx3");
    chk(rd1_hits == 1 && rd0_hits == 1, "R3 port1 read", 32'(rd1_hits), 1);
    rd(NENT - 1, 1, "R3 port1 top entry");
    rd(0, 0, "R4 port0 entry0");
    wr(NENT - 1, 32'hDEAD_BEEF, "R2 write top entry");
    rd(NENT - 1, 0, "R6 top entry read back");

    w0 = wr_hits; r0 = rd0_hits; r1 = rd1_hits;
    bus_op(32'h0020_0000, 0, '0, 4'hF, 32'd0, 1, "R7 outside window");
    bus_op(32'h0001_0004, 0, '0, 4'hF, 32'd0, 1, "R7 control window");
    bus_op(32'h0000_0008, 1, 32'h5555_AAAA, 4'hF, 32'd0, 1, "R7 config window write");
    bus_op(BASE + 32'h40, 0, '0, 4'hF, 32'd0, 1, "R7 pad bits set");
    bus_op(BASE + P1 + 32'd5, 1, 32'hCAFE_F00D, 4'hF, 32'd0, 1, "R7 write to port1 window");
    chk(wr_hits == w0 && rd0_hits == r0 && rd1_hits == r1, "R7 no array access",
        32'(wr_hits + rd0_hits + rd1_hits), 32'(w0 + r0 + r1));
    rd(5, 0, "R7 idx5 unchanged");

    bus_op(BASE + 32'd7, 1, 32'h0BAD_0BAD, 4'h3, 32'd0, 1, "R8 partial select write");
    chk(wr_hits == w0, "R8 no write port use", 32'(wr_hits), 32'(w0));
    rd(7, 0, "R8 idx7 unchanged");

    bus_op(BASE + 32'd1, 0, '0, 4'hF, shadow[1], 3, "R9 read with stray strobe",
           1, BASE + 32'd2, 32'h7777_7777);
    chk(wr_hits == w0, "R9 stray write dropped", 32'(wr_hits), 32'(w0));
    rd(2, 0, "R9 idx2 unchanged");

    wr(2, 32'h0F0F_1234, "R2 write idx2");
    rd(2, 1, "R6 port1 read after write");

    repeat (4) @(negedge clk);
    done = 1;
    report();
  end

endmodule